// File: doc/BRIEF.md
# Packed Instruction Fetch Unpacker

This block sits between an instruction sequencer and a narrow external read port. Instructions are 48 bits wide and are stored in pairs, with each pair filling three consecutive 32-bit memory words. The external data path carries 16 bits per beat. The sequencer hands over an instruction index. The block maps that index to the pair's first word, works out which three halfwords hold the wanted instruction, and reads them one beat at a time. It then presents the rebuilt 48-bit word on a ready/valid output.

Code may only run from the first external bank. The bank's first word and its exclusive end word are parameters of the block. A request whose instruction would reach past the end word is rejected with a one-cycle error pulse, and no memory traffic is issued for it. A separate combinational path takes an instruction count N and returns the first word address after N packed instructions placed at the bank base. Data buffers can safely start at that address.

Top module: `insn_unpack`

## Requirements
- R1: A synchronous active-low reset (`rst_n` = 0 at a clock edge) drops any fetch in progress, including partly gathered beats. From the next cycle, `req_ready` = 1, `out_valid` = 0, `mem_req` = 0 and `fetch_err` = 0.
- R2: Index i belongs to the pair whose first word is BANK_BASE + 3·(i>>1). Halfword h of the pair (h = 0..5) is read at word address (pair word + h/2). It is on the low half of the data word when `mem_hi` = 0 and the high half when `mem_hi` = 1. An even index reads halfwords 0, 1, 2 and an odd index reads halfwords 3, 4, 5, always in ascending order.
- R3: Beats are packed little-endian. The first beat read lands in `out_instr[15:0]`, the second in `[31:16]` and the third in `[47:32]`.
- R4: `mem_req` is a single-cycle pulse. Exactly three beats are requested per accepted in-bank fetch, and no new beat is requested until `mem_rvalid` has answered the previous one.
- R5: Only one fetch is in flight. After a request is accepted, `req_ready` stays 0 until the result has been taken with `out_valid` and `out_ready` both 1.
- R6: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and `out_instr` does not change.
- R7: A request is out of bank when its last word (pair word + 1 for an even index, + 2 for an odd index) is at or above BANK_END. Such a request issues no `mem_req`. It raises `fetch_err` for exactly the cycle after acceptance and never sets `out_valid`, and the block is ready again in that same cycle.
- R8: `data_start` equals BANK_BASE + ceil(3·`blk_count`/2), computed combinationally. For example, 2048 instructions from base 0x0020_0000 give 0x0020_0C00.
- R9: A response may arrive any number of cycles after its request. A `mem_rvalid` pulse that arrives while no beat is outstanding is ignored and does not affect later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Sequencer presents an index |
| req_ready | output | 1 | Block can accept an index |
| req_index | input | IDX_W | Instruction index relative to the bank base |
| mem_req | output | 1 | One-cycle read beat request |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_hi | output | 1 | 1 selects bits [31:16] of the word, 0 bits [15:0] |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read halfword |
| out_valid | output | 1 | Rebuilt instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_instr | output | 48 | Rebuilt instruction |
| fetch_err | output | 1 | One-cycle pulse for an out-of-bank request |
| blk_count | input | IDX_W+1 | Instruction count for the data offset |
| data_start | output | ADDR_W | First word free after the packed block |

## Verification
The sequencing state and the halfword pointer can both go wrong. A bad pointer shows up one beat later, as a wrong `mem_addr`/`mem_hi`, or as a slice of `out_instr` that does not match the independently computed memory pattern once the third beat returns. A bad beat counter either ends the fetch early or late; this shows as a wrong total of beats per fetch, or as the upper slices being shifted when `out_valid` rises. A stuck busy state shows up straight away: `req_ready` stays low and no result arrives. Reset is tried in the middle of a fetch, and a stray response is injected while idle, so that any state left over would corrupt the very next instruction.

// File: rtl/insn_unpack_pkg.sv
// Shared constants and types for the packed instruction fetch unpacker.
// Assumes the instruction width is a whole multiple of the beat width.
package insn_unpack_pkg;
    localparam int INSTR_W = 48;
    localparam int BEAT_W  = 16;
    localparam int BEATS   = INSTR_W / BEAT_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } fetch_state_e;
endpackage

// File: rtl/insn_addr_map.sv
// Maps an instruction index onto the three-words-per-pair packing.
// Produces the halfword address of the first beat and a bank-limit flag.
// Assumes IDX_W is smaller than ADDR_W, so the arithmetic cannot wrap.
module insn_addr_map #(
    parameter int          ADDR_W    = 32,
    parameter int          IDX_W     = 24,
    parameter int unsigned BANK_BASE = 32'h0020_0000,
    parameter int unsigned BANK_END  = 32'h0100_0000
) (
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W:0]   hw_start,
    output logic              in_bank
);
    localparam int EXT_W = ADDR_W + 2;
    localparam int HW_W  = ADDR_W + 1;

    logic [EXT_W-1:0] pair_idx;
    logic [EXT_W-1:0] pair_off;
    logic [EXT_W-1:0] word0;
    logic [EXT_W-1:0] last_word;

    // Pair word, last touched word and first halfword for this index.
    always_comb begin
        pair_idx  = EXT_W'(index >> 1);
        pair_off  = (pair_idx << 1) + pair_idx;
        word0     = EXT_W'(BANK_BASE) + pair_off;
        last_word = word0 + (index[0] ? EXT_W'(2) : EXT_W'(1));
        in_bank   = last_word < EXT_W'(BANK_END);
        hw_start  = {ADDR_W'(word0), 1'b0} + (index[0] ? HW_W'(3) : HW_W'(0));
    end
endmodule

// File: rtl/insn_beat_ctrl.sv
// Sequences one fetch: accepts an index, issues three single beats in
// ascending halfword order, waits for each response, then holds the
// result until the consumer takes it. Rejects out-of-bank requests.
// Assumes the memory answers each request with exactly one rvalid pulse.
module insn_beat_ctrl
    import insn_unpack_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              in_bank,
    input  logic [ADDR_W:0]   hw_start,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_hi,
    input  logic              mem_rvalid,
    output logic              beat_take,
    output logic              asm_clear,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              fetch_err
);
    localparam int CNT_W = $clog2(BEATS);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

    fetch_state_e     state_q;
    logic [ADDR_W:0]  hw_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;

    // State, halfword pointer, beat counter and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hw_q    <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (in_bank) begin
                            hw_q    <= hw_start;
                            cnt_q   <= '0;
                            state_q <= ST_ISSUE;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (cnt_q == LAST_BEAT) begin
                            state_q <= ST_DONE;
                        end else begin
                            cnt_q   <= cnt_q + 1'b1;
                            hw_q    <= hw_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_DONE: begin
                    if (out_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Handshake and memory-side outputs decoded from the state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_ISSUE);
        mem_addr  = hw_q[ADDR_W:1];
        mem_hi    = hw_q[0];
        beat_take = (state_q == ST_WAIT) && mem_rvalid;
        asm_clear = (state_q == ST_IDLE) && req_valid && in_bank;
        out_valid = (state_q == ST_DONE);
        fetch_err = err_q;
    end
endmodule

// File: rtl/insn_shift_asm.sv
// Builds the instruction from beats: each new beat enters at the top and
// earlier beats move down, so the first beat ends in the lowest slice.
// Assumes exactly WIDTH/BEAT_W beats are taken between clears.
module insn_shift_asm #(
    parameter int WIDTH  = 48,
    parameter int BEAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [BEAT_W-1:0] din,
    output logic [WIDTH-1:0]  word
);
    // Clear on a new fetch, shift in one beat per response.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= '0;
        end else if (take) begin
            word <= {din, word[WIDTH-1:BEAT_W]};
        end
    end
endmodule

// File: rtl/insn_data_offset.sv
// Returns the first word after N packed instructions at the bank base:
// base + ceil(3N/2). Purely combinational.
module insn_data_offset #(
    parameter int          ADDR_W    = 32,
    parameter int          IDX_W     = 24,
    parameter int unsigned BANK_BASE = 32'h0020_0000
) (
    input  logic [IDX_W:0]    blk_count,
    output logic [ADDR_W-1:0] data_start
);
    localparam int EXT_W = ADDR_W + 2;

    logic [EXT_W-1:0] n_ext;
    logic [EXT_W-1:0] span3;
    logic [EXT_W-1:0] sum;

    // Three halves per instruction, rounded up to a whole word.
    always_comb begin
        n_ext      = EXT_W'(blk_count);
        span3      = (n_ext << 1) + n_ext;
        sum        = EXT_W'(BANK_BASE) + ((span3 + EXT_W'(1)) >> 1);
        data_start = ADDR_W'(sum);
    end
endmodule

// File: rtl/insn_unpack.sv
// Top of the packed instruction fetch unpacker: index mapping, beat
// sequencing, beat assembly and the data offset path.
// Assumes a single-port read memory answering each beat with one rvalid.
module insn_unpack
    import insn_unpack_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          IDX_W     = 24,
    parameter int unsigned BANK_BASE = 32'h0020_0000,
    parameter int unsigned BANK_END  = 32'h0100_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IDX_W-1:0]   req_index,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_hi,
    input  logic               mem_rvalid,
    input  logic [BEAT_W-1:0]  mem_rdata,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_instr,
    output logic               fetch_err,
    input  logic [IDX_W:0]     blk_count,
    output logic [ADDR_W-1:0]  data_start
);
    logic [ADDR_W:0] hw_start;
    logic            in_bank;
    logic            beat_take;
    logic            asm_clear;

    insn_addr_map #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .BANK_BASE(BANK_BASE), .BANK_END(BANK_END)
    ) u_map (
        .index(req_index), .hw_start(hw_start), .in_bank(in_bank)
    );

    insn_beat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .in_bank(in_bank), .hw_start(hw_start),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_hi(mem_hi),
        .mem_rvalid(mem_rvalid),
        .beat_take(beat_take), .asm_clear(asm_clear),
        .out_valid(out_valid), .out_ready(out_ready),
        .fetch_err(fetch_err)
    );

    insn_shift_asm #(.WIDTH(INSTR_W), .BEAT_W(BEAT_W)) u_asm (
        .clk(clk), .rst_n(rst_n),
        .clear(asm_clear), .take(beat_take),
        .din(mem_rdata), .word(out_instr)
    );

    insn_data_offset #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK_BASE(BANK_BASE)
    ) u_off (
        .blk_count(blk_count), .data_start(data_start)
    );
endmodule

// File: rtl/insn_unpack_chk.sv
// Protocol checker for insn_unpack, attached by bind below.
module insn_unpack_chk #(
    parameter int          ADDR_W    = 32,
    parameter int unsigned BANK_BASE = 32'h0020_0000,
    parameter int unsigned BANK_END  = 32'h0100_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [47:0]       out_instr,
    input logic              fetch_err
);
    logic beat_open_q;

    // Tracks whether a requested beat still awaits its response.
    always_ff @(posedge clk) begin
        if (!rst_n)          beat_open_q <= 1'b0;
        else if (mem_req)    beat_open_q <= 1'b1;
        else if (mem_rvalid) beat_open_q <= 1'b0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !out_valid && !mem_req && !fetch_err)); // R1
    AST_BEAT_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr >= ADDR_W'(BANK_BASE)) && (mem_addr < ADDR_W'(BANK_END))); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R4
    AST_ONE_BEAT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        beat_open_q |-> !mem_req); // R4
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready || fetch_err)); // R5
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_instr))); // R6
    AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |-> (!out_valid && !mem_req && req_ready)); // R7
endmodule

bind insn_unpack insn_unpack_chk #(
    .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE), .BANK_END(BANK_END)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .fetch_err(fetch_err)
);

// File: tb/sim_insn_unpack.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them as the design answers. Memory is a latency model.
module sim_insn_unpack;
    localparam int          ADDR_W = 32;
    localparam int          IDX_W  = 24;
    localparam int unsigned BASE   = 32'h0020_0000;
    localparam int unsigned BEND   = 32'h0100_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [IDX_W-1:0]  req_index = '0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_hi;
    logic              mem_rvalid;
    logic [15:0]       mem_rdata;
    logic              out_valid;
    logic              out_ready;
    logic [47:0]       out_instr;
    logic              fetch_err;
    logic [IDX_W:0]    blk_count = '0;
    logic [ADDR_W-1:0] data_start;

    logic        mdl_rv = 1'b0;
    logic [15:0] mdl_rd = '0;
    logic        stray_rv = 1'b0;
    logic        hold_out = 1'b0;
    logic        rnd_mode = 1'b0;
    logic [7:0]  cyc = '0;
    int          beats = 0;
    int          n_pass = 0;
    int          n_total = 0;
    bit          done = 1'b0;

    bit          eq_err[$];
    logic [47:0] eq_ins[$];
    int unsigned eq_idx[$];

    assign mem_rvalid = mdl_rv | stray_rv;
    assign mem_rdata  = stray_rv ? 16'hDEAD : mdl_rd;
    assign out_ready  = !hold_out && !(rnd_mode && (cyc[0] ^ cyc[2]));

    always #10 clk = ~clk;

    insn_unpack u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_hi(mem_hi),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
        .fetch_err(fetch_err),
        .blk_count(blk_count), .data_start(data_start)
    );

    function automatic logic [15:0] mem_pat(input logic [63:0] hw);
        return hw[15:0] ^ hw[31:16] ^ 16'h5A5A;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    endtask

    // Stall pattern source for out_ready.
    always @(negedge clk) cyc <= cyc + 8'd1;

    // Memory model: one beat at a time, latency 1..3 by address.
    initial begin
        int          wait_cnt = 0;
        logic [63:0] hw = '0;
        forever begin
            @(negedge clk);
            mdl_rv = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    mdl_rv = 1'b1;
                    mdl_rd = mem_pat(hw);
                end
            end else if (rst_n && mem_req) begin
                hw = 64'({mem_addr, mem_hi});
                beats++;
                wait_cnt = 1 + int'(hw % 3);
            end
        end
    end

    // Monitor: compares each result or error pulse with the queue head.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n && out_valid && out_ready) begin
                if (eq_idx.size() == 0) begin
                    check(1'b0, "R5 unexpected result", 64'(out_instr), 64'h0);
                end else begin
                    automatic bit          e  = eq_err.pop_front();
                    automatic logic [47:0] ex = eq_ins.pop_front();
                    automatic int unsigned ix = eq_idx.pop_front();
                    check(!e && out_instr == ex,
                          $sformatf("R2 R3 R9 index %0d", ix), 64'(out_instr), 64'(ex));
                end
            end
            if (rst_n && fetch_err) begin
                if (eq_idx.size() == 0) begin
                    check(1'b0, "R7 unexpected error", 64'h1, 64'h0);
                end else begin
                    automatic bit          e  = eq_err.pop_front();
                    automatic logic [47:0] ex = eq_ins.pop_front();
                    automatic int unsigned ix = eq_idx.pop_front();
                    check(e, $sformatf("R7 error for index %0d", ix), 64'h1, 64'(e));
                    if (ex != 48'h0) check(1'b0, "R7 queue", 64'(ex), 64'h0);
                end
            end
        end
    end

    // Driver: push the expected outcome, then present the index.
    task automatic fetch(input int unsigned idx);
        logic [63:0] p;
        logic [63:0] last;
        logic [63:0] hw0;
        bit          e;
        p    = 64'(BASE) + 64'(3) * 64'(idx >> 1);
        last = p + ((idx & 1) != 0 ? 64'd2 : 64'd1);
        e    = last >= 64'(BEND);
        hw0  = 64'(2) * p + ((idx & 1) != 0 ? 64'd3 : 64'd0);
        eq_err.push_back(e);
        eq_ins.push_back(e ? 48'h0 : {mem_pat(hw0 + 2), mem_pat(hw0 + 1), mem_pat(hw0)});
        eq_idx.push_back(idx);
        req_valid = 1'b1;
        req_index = IDX_W'(idx);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (eq_idx.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 64'h0, 64'h1);
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        int b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(req_ready && !out_valid && !mem_req && !fetch_err, "R1 reset state",
              64'({req_ready, out_valid, mem_req, fetch_err}), 64'b1000);

        // R2 R3: even and odd indices, R4 beat count per fetch
        b0 = beats;
        fetch(0);
        drain();
        check(beats == b0 + 3, "R4 three beats per fetch", 64'(beats - b0), 64'd3);
        foreach (eq_idx[k]) begin end
        fetch(1); fetch(2); fetch(3); fetch(7); fetch(1000); fetch(4095);
        drain();

        // R7: boundary indices around the bank end
        fetch(9786707); fetch(9786708);
        drain();
        b0 = beats;
        fetch(9786709);
        drain();
        check(beats == b0, "R7 no beat for out-of-bank request", 64'(beats - b0), 64'd0);
        fetch(9786710); fetch(16777215); fetch(9);
        drain();

        // R6 R5: hold the result under backpressure
        hold_out = 1'b1;
        fetch(5);
        while (!out_valid) @(negedge clk);
        begin
            automatic logic [47:0] snap = out_instr;
            repeat (4) @(negedge clk);
            check(out_valid && out_instr == snap, "R6 held result",
                  64'(out_instr), 64'(snap));
            check(!req_ready, "R5 busy while result pending", 64'(req_ready), 64'd0);
        end
        hold_out = 1'b0;
        drain();

        // R5 R6: irregular consumer stalls over a run of fetches
        rnd_mode = 1'b1;
        for (int i = 20; i < 26; i++) fetch(i);
        drain();
        rnd_mode = 1'b0;

        // R9: stray response while idle is ignored
        stray_rv = 1'b1;
        @(negedge clk);
        stray_rv = 1'b0;
        @(negedge clk);
        check(req_ready && !out_valid, "R9 stray response ignored",
              64'({req_ready, out_valid}), 64'b10);
        fetch(6);
        drain();

        // R1: reset in the middle of a fetch
        b0 = beats;
        fetch(11);
        while (beats == b0) @(negedge clk);
        rst_n = 1'b0;
        eq_err.delete(); eq_ins.delete(); eq_idx.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !out_valid && !mem_req, "R1 reset mid-fetch",
              64'({req_ready, out_valid, mem_req}), 64'b100);
        repeat (8) @(negedge clk);
        fetch(11);
        drain();

        // R8: data offset after a packed block
        blk_count = 25'd2048;
        #1 check(data_start == 32'h0020_0C00, "R8 N=2048", 64'(data_start), 64'h200C00);
        blk_count = 25'd1;
        #1 check(data_start == 32'h0020_0002, "R8 N=1", 64'(data_start), 64'h200002);
        blk_count = 25'd7;
        #1 check(data_start == 32'h0020_000B, "R8 N=7", 64'(data_start), 64'h20000B);
        blk_count = 25'd0;
        #1 check(data_start == 32'h0020_0000, "R8 N=0", 64'(data_start), 64'h200000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule